// File: doc/BRIEF.md
# Erase Range Walker

This block turns one erase request, given as a start offset and a byte length over a flash array, into a sequence of single-block erase requests. The array is described by a small table of regions. Each region has a start offset, a power-of-two block size given as a shift, and a block count. A region count input says how many table entries are valid, up to four. The array is split into equal chips of `2**CHIP_SHIFT` bytes, and there are `NUM_CHIPS` of them.

A request is accepted on `startReq` while the block is idle. The block first finds the region that holds the start offset and the region that holds the end offset (start plus length). Both ends must be aligned to the block size of their own region. A misaligned range is refused before any erase happens. An accepted range is walked one block at a time. Each block request carries a chip index, an address inside the chip and a size. The block waits for the external eraser to report completion and status before it issues the next request. The walk moves to the next region at a region's end, carries into the next chip when the chip size is crossed, and stops at the first nonzero status.

The region table inputs must stay constant while `busy` is high. Requested offsets are assumed to lie inside the chips.

Top module: `erase_range_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `blkValid`, `done` and `alignErr` are all 0.
- R2: The start region is found by stepping past every valid region whose start is at or below the offset and then taking the last region passed. The request is refused if no region was passed or if the offset is not a multiple of that region's block size (`2**shift`).
- R3: The end offset (start + length) is looked up in the same way. The request is refused if no region was passed or if the end offset is not a multiple of that region's block size.
- R4: A refused request pulses `done` for one cycle with `alignErr` at 1 and `errCode` at 0, and raises `blkValid` at no point.
- R5: The first block request has chip index = offset >> `CHIP_SHIFT` and in-chip address = offset mod `2**CHIP_SHIFT`.
- R6: Each block request has size `2**shift` of the current region. After a block completes, the address and offset grow by that size and the remaining length shrinks by it. The walk ends with `done` when no length remains.
- R7: When the offset reaches region start + size × count, the walk uses the next region. This only happens if that next region is among the valid ones. Otherwise it stays on the current region.
- R8: When the in-chip address reaches `2**CHIP_SHIFT`, it wraps to 0 and the chip index grows by one. The walk ends with `done` and no error once the chip index reaches `NUM_CHIPS`.
- R9: A nonzero `blkStatus` reported with `blkDone` ends the walk at once. `done` then pulses with `errCode` equal to that status, and no further request is issued.
- R10: A block request holds `blkValid`, `blkChip`, `blkAddr` and `blkSize` steady until `blkDone`. A request of length 0 that passes both checks completes with no block request.
- R11: Only the first `numRegions` table entries take part in lookup. With `numRegions` at 0, every request is refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Starts a request while idle |
| reqOffset | input | OFS_W | Start offset of the erase range |
| reqLength | input | OFS_W | Length of the erase range in bytes |
| numRegions | input | clog2(MAX_REGIONS+1) | Number of valid table entries |
| regStartFlat | input | MAX_REGIONS*OFS_W | Region start offsets, entry k at bits k*OFS_W |
| regShiftFlat | input | MAX_REGIONS*SHIFT_W | Region block-size shifts |
| regBlocksFlat | input | MAX_REGIONS*CNT_W | Region block counts |
| blkValid | output | 1 | A block request is pending |
| blkChip | output | clog2(NUM_CHIPS+1) | Chip index of the pending block |
| blkAddr | output | CHIP_SHIFT | Address inside the chip |
| blkSize | output | OFS_W | Block size in bytes |
| blkDone | input | 1 | The pending block has completed |
| blkStatus | input | ST_W | Completion status, 0 means success |
| busy | output | 1 | A request is being checked or walked |
| done | output | 1 | One-cycle pulse at the end of a request |
| alignErr | output | 1 | The last request was refused; held until the next start |
| errCode | output | ST_W | Status that aborted the last walk, else 0 |

## Verification
The bound checker watches the handshake rules on every cycle. A pending request must not change until it is acknowledged. The chip index must stay below the chip count while a request is pending. A failing status must end the walk in the next cycle with the matching code. A refusal must never follow a cycle in which a request was shown, and a start must take effect at once. The bench's sweeps over offsets, lengths and region counts are what show that the region lookup, the alignment decisions, the region steps and the chip carries produce the right sequence of blocks. Those results depend on the arithmetic over whole walks, not on any single cycle.

// File: rtl/erw_pkg.sv
package erw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_ISSUE = 2'd2
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic initWalk;
    logic advance;
  } walkStrobe_t;
endpackage

// File: rtl/erw_datapath.sv
module erw_datapath
  import erw_pkg::*;
#(
  parameter int OFS_W       = 16,
  parameter int MAX_REGIONS = 4,
  parameter int SHIFT_W     = 4,
  parameter int CNT_W       = 8,
  parameter int CHIP_SHIFT  = 10,
  parameter int NUM_CHIPS   = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  walkStrobe_t                        strobe,
  input  logic [OFS_W-1:0]                   reqOffset,
  input  logic [OFS_W-1:0]                   reqLength,
  input  logic [$clog2(MAX_REGIONS+1)-1:0]   numRegions,
  input  logic [MAX_REGIONS*OFS_W-1:0]       regStartFlat,
  input  logic [MAX_REGIONS*SHIFT_W-1:0]     regShiftFlat,
  input  logic [MAX_REGIONS*CNT_W-1:0]       regBlocksFlat,
  output logic                               misaligned,
  output logic                               zeroLen,
  output logic                               lastStep,
  output logic [$clog2(NUM_CHIPS+1)-1:0]     blkChip,
  output logic [CHIP_SHIFT-1:0]              blkAddr,
  output logic [OFS_W-1:0]                   blkSize
);
  localparam int W      = OFS_W + 1;
  localparam int RN_W   = $clog2(MAX_REGIONS + 1);
  localparam int RI_W   = (MAX_REGIONS > 1) ? $clog2(MAX_REGIONS) : 1;
  localparam int CHIP_W = $clog2(NUM_CHIPS + 1);

  logic [OFS_W-1:0]   rStart  [MAX_REGIONS];
  logic [SHIFT_W-1:0] rShift  [MAX_REGIONS];
  logic [CNT_W-1:0]   rBlocks [MAX_REGIONS];

  for (genvar k = 0; k < MAX_REGIONS; k++) begin : g_unpack
    assign rStart[k]  = regStartFlat[k*OFS_W +: OFS_W];
    assign rShift[k]  = regShiftFlat[k*SHIFT_W +: SHIFT_W];
    assign rBlocks[k] = regBlocksFlat[k*CNT_W +: CNT_W];
  end

  // number of valid regions whose start is at or below v, stopping at the first miss
  function automatic logic [RN_W-1:0] countBelow(input logic [W-1:0] v);
    logic            go;
    logic [RN_W-1:0] cnt;
    go  = 1'b1;
    cnt = '0;
    for (int k = 0; k < MAX_REGIONS; k++) begin
      if (go && (RN_W'(k) < numRegions) && (v >= W'(rStart[k]))) cnt = cnt + 1'b1;
      else go = 1'b0;
    end
    return cnt;
  endfunction

  logic [OFS_W-1:0]  ofsReqR, lenReqR;
  logic [W-1:0]      walkOfs;
  logic [OFS_W-1:0]  lenR;
  logic [CHIP_SHIFT-1:0] addrR;
  logic [CHIP_W-1:0] chipR;
  logic [RI_W-1:0]   regR;

  logic [W-1:0]    reqEnd;
  logic [RN_W-1:0] sCnt, eCnt;
  logic [RI_W-1:0] sIdx, eIdx;
  logic [W-1:0]    sMask, eMask;

  always_comb begin
    reqEnd = W'(ofsReqR) + W'(lenReqR);
    sCnt   = countBelow(W'(ofsReqR));
    eCnt   = countBelow(reqEnd);
    sIdx   = RI_W'(sCnt - 1'b1);
    eIdx   = RI_W'(eCnt - 1'b1);
    sMask  = (W'(1) << rShift[sIdx]) - W'(1);
    eMask  = (W'(1) << rShift[eIdx]) - W'(1);
    misaligned = (sCnt == '0) || (eCnt == '0) ||
                 ((W'(ofsReqR) & sMask) != '0) || ((reqEnd & eMask) != '0);
    zeroLen = (lenReqR == '0);
  end

  logic [W-1:0] curSize, nextAddr, nextOfs, regionEnd;
  logic         chipCross;

  always_comb begin
    curSize   = W'(1) << rShift[regR];
    nextAddr  = W'(addrR) + curSize;
    nextOfs   = walkOfs + curSize;
    regionEnd = W'(rStart[regR]) + (W'(rBlocks[regR]) << rShift[regR]);
    chipCross = (nextAddr >> CHIP_SHIFT) != '0;
    lastStep  = (W'(lenR) <= curSize) ||
                (chipCross && ((32'(chipR) + 1) >= NUM_CHIPS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ofsReqR <= '0;
      lenReqR <= '0;
    end else if (strobe.latchReq) begin
      ofsReqR <= reqOffset;
      lenReqR <= reqLength;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      walkOfs <= '0;
      lenR    <= '0;
      addrR   <= '0;
      chipR   <= '0;
      regR    <= '0;
    end else if (strobe.initWalk) begin
      walkOfs <= W'(ofsReqR);
      lenR    <= lenReqR;
      addrR   <= ofsReqR[CHIP_SHIFT-1:0];
      chipR   <= CHIP_W'(ofsReqR >> CHIP_SHIFT);
      regR    <= sIdx;
    end else if (strobe.advance) begin
      walkOfs <= nextOfs;
      lenR    <= lenR - curSize[OFS_W-1:0];
      if ((nextOfs == regionEnd) && ((RN_W'(regR) + 1'b1) < numRegions))
        regR <= regR + 1'b1;
      if (chipCross) begin
        addrR <= '0;
        chipR <= chipR + 1'b1;
      end else begin
        addrR <= nextAddr[CHIP_SHIFT-1:0];
      end
    end
  end

  assign blkChip = chipR;
  assign blkAddr = addrR;
  assign blkSize = curSize[OFS_W-1:0];
endmodule

// File: rtl/erw_ctrl.sv
module erw_ctrl
  import erw_pkg::*;
#(
  parameter int ST_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            misaligned,
  input  logic            zeroLen,
  input  logic            lastStep,
  input  logic            blkDone,
  input  logic [ST_W-1:0] blkStatus,
  output walkStrobe_t     strobe,
  output logic            blkValid,
  output logic            busy,
  output logic            done,
  output logic            alignErr,
  output logic [ST_W-1:0] errCode
);
  walkState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (startReq) begin
        strobe.latchReq = 1'b1;
        nextState       = ST_CHECK;
      end
      ST_CHECK: begin
        if (!misaligned && !zeroLen) begin
          strobe.initWalk = 1'b1;
          nextState       = ST_ISSUE;
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_ISSUE: if (blkDone) begin
        if (blkStatus != '0) begin
          nextState = ST_IDLE;
        end else begin
          strobe.advance = 1'b1;
          if (lastStep) nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      alignErr <= 1'b0;
      errCode  <= '0;
    end else begin
      state <= nextState;
      done  <= (state != ST_IDLE) && (nextState == ST_IDLE);
      if (strobe.latchReq) begin
        alignErr <= 1'b0;
        errCode  <= '0;
      end else if (state == ST_CHECK && misaligned) begin
        alignErr <= 1'b1;
      end else if (state == ST_ISSUE && blkDone && blkStatus != '0) begin
        errCode <= blkStatus;
      end
    end
  end

  assign blkValid = (state == ST_ISSUE);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/erase_range_walker.sv
module erase_range_walker
  import erw_pkg::*;
#(
  parameter int OFS_W       = 16,
  parameter int MAX_REGIONS = 4,
  parameter int SHIFT_W     = 4,
  parameter int CNT_W       = 8,
  parameter int CHIP_SHIFT  = 10,
  parameter int NUM_CHIPS   = 4,
  parameter int ST_W        = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               startReq,
  input  logic [OFS_W-1:0]                   reqOffset,
  input  logic [OFS_W-1:0]                   reqLength,
  input  logic [$clog2(MAX_REGIONS+1)-1:0]   numRegions,
  input  logic [MAX_REGIONS*OFS_W-1:0]       regStartFlat,
  input  logic [MAX_REGIONS*SHIFT_W-1:0]     regShiftFlat,
  input  logic [MAX_REGIONS*CNT_W-1:0]       regBlocksFlat,
  output logic                               blkValid,
  output logic [$clog2(NUM_CHIPS+1)-1:0]     blkChip,
  output logic [CHIP_SHIFT-1:0]              blkAddr,
  output logic [OFS_W-1:0]                   blkSize,
  input  logic                               blkDone,
  input  logic [ST_W-1:0]                    blkStatus,
  output logic                               busy,
  output logic                               done,
  output logic                               alignErr,
  output logic [ST_W-1:0]                    errCode
);
  walkStrobe_t strobe;
  logic misaligned, zeroLen, lastStep;

  erw_ctrl #(.ST_W(ST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .misaligned(misaligned), .zeroLen(zeroLen), .lastStep(lastStep),
    .blkDone(blkDone), .blkStatus(blkStatus), .strobe(strobe),
    .blkValid(blkValid), .busy(busy), .done(done),
    .alignErr(alignErr), .errCode(errCode)
  );

  erw_datapath #(
    .OFS_W(OFS_W), .MAX_REGIONS(MAX_REGIONS), .SHIFT_W(SHIFT_W),
    .CNT_W(CNT_W), .CHIP_SHIFT(CHIP_SHIFT), .NUM_CHIPS(NUM_CHIPS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqOffset(reqOffset), .reqLength(reqLength), .numRegions(numRegions),
    .regStartFlat(regStartFlat), .regShiftFlat(regShiftFlat),
    .regBlocksFlat(regBlocksFlat),
    .misaligned(misaligned), .zeroLen(zeroLen), .lastStep(lastStep),
    .blkChip(blkChip), .blkAddr(blkAddr), .blkSize(blkSize)
  );
endmodule

// File: rtl/erw_checker.sv
module erw_checker #(
  parameter int OFS_W      = 16,
  parameter int CHIP_SHIFT = 10,
  parameter int NUM_CHIPS  = 4,
  parameter int ST_W       = 4
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           startReq,
  input logic                           blkValid,
  input logic [$clog2(NUM_CHIPS+1)-1:0] blkChip,
  input logic [CHIP_SHIFT-1:0]          blkAddr,
  input logic [OFS_W-1:0]               blkSize,
  input logic                           blkDone,
  input logic [ST_W-1:0]                blkStatus,
  input logic                           busy,
  input logic                           done,
  input logic                           alignErr,
  input logic [ST_W-1:0]                errCode
);
  // R10: pending request is held until acknowledged
  assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rstN)
    (blkValid && !blkDone) |=> (blkValid && $stable(blkChip) && $stable(blkAddr) && $stable(blkSize)));

  // R8: no request ever targets a chip past the last one
  assert_chip_in_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    blkValid |-> (32'(blkChip) < NUM_CHIPS));

  // R9: a failing status ends the walk with its code
  assert_abort_on_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    (blkValid && blkDone && blkStatus != '0) |=> (!blkValid && done && errCode == $past(blkStatus)));

  // R4: a refusal is never preceded by a shown request
  assert_reject_no_request_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && alignErr) |-> !$past(blkValid));

  // R1: a start from idle makes the block busy next cycle
  assert_start_takes_R1: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> (busy && !done));
endmodule

bind erase_range_walker erw_checker #(
  .OFS_W(OFS_W), .CHIP_SHIFT(CHIP_SHIFT), .NUM_CHIPS(NUM_CHIPS), .ST_W(ST_W)
) u_erw_checker (
  .clk(clk), .rstN(rstN), .startReq(startReq), .blkValid(blkValid),
  .blkChip(blkChip), .blkAddr(blkAddr), .blkSize(blkSize),
  .blkDone(blkDone), .blkStatus(blkStatus), .busy(busy), .done(done),
  .alignErr(alignErr), .errCode(errCode)
);

// File: tb/test_erase_range_walker.sv
module test_erase_range_walker;
  localparam int OFS_W = 16, MAX_REGIONS = 4, SHIFT_W = 4, CNT_W = 8;
  localparam int CHIP_SHIFT = 10, NUM_CHIPS = 4, ST_W = 4;
  localparam int CHIP_SIZE = 1 << CHIP_SHIFT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [OFS_W-1:0] reqOffset = '0, reqLength = '0;
  logic [2:0] numRegions = 3'd4;
  logic [MAX_REGIONS*OFS_W-1:0] regStartFlat;
  logic [MAX_REGIONS*SHIFT_W-1:0] regShiftFlat;
  logic [MAX_REGIONS*CNT_W-1:0] regBlocksFlat;
  logic blkValid, busy, done, alignErr;
  logic [2:0] blkChip;
  logic [CHIP_SHIFT-1:0] blkAddr;
  logic [OFS_W-1:0] blkSize;
  logic blkDone = 1'b0;
  logic [ST_W-1:0] blkStatus = '0;
  logic [ST_W-1:0] errCode;

  always #5 clk = ~clk;

  erase_range_walker #(
    .OFS_W(OFS_W), .MAX_REGIONS(MAX_REGIONS), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W),
    .CHIP_SHIFT(CHIP_SHIFT), .NUM_CHIPS(NUM_CHIPS), .ST_W(ST_W)
  ) i_erase_range_walker (
    .clk(clk), .rstN(rstN), .startReq(startReq), .reqOffset(reqOffset),
    .reqLength(reqLength), .numRegions(numRegions), .regStartFlat(regStartFlat),
    .regShiftFlat(regShiftFlat), .regBlocksFlat(regBlocksFlat),
    .blkValid(blkValid), .blkChip(blkChip), .blkAddr(blkAddr), .blkSize(blkSize),
    .blkDone(blkDone), .blkStatus(blkStatus), .busy(busy), .done(done),
    .alignErr(alignErr), .errCode(errCode)
  );

  // region table: 16B x8 @0, 64B x4 @128, 32B x20 @384, 256B x12 @1024
  int rs [4] = '{0, 128, 384, 1024};
  int rsh[4] = '{4, 6, 5, 8};
  int rb [4] = '{8, 4, 20, 12};

  initial begin
    for (int k = 0; k < 4; k++) begin
      regStartFlat[k*OFS_W +: OFS_W]     = OFS_W'(rs[k]);
      regShiftFlat[k*SHIFT_W +: SHIFT_W] = SHIFT_W'(rsh[k]);
      regBlocksFlat[k*CNT_W +: CNT_W]    = CNT_W'(rb[k]);
    end
  end

  int total = 0, bad = 0;
  int cyc = 0;
  bit finished = 0;

  int expRej, expN;
  int expChip[64], expAddr[64], expSize[64];

  function automatic int lookupM(int v, int n);
    int i = 0;
    while (i < n && v >= rs[i]) i++;
    return i - 1;
  endfunction

  // arithmetic reference of the walk
  task automatic model(int ofs, int len, int n);
    int s, e, chip, addr, r, o, rem, sz;
    expN = 0;
    s = lookupM(ofs, n);
    e = lookupM(ofs + len, n);
    expRej = (s < 0 || e < 0) ? 1 : 0;
    if (!expRej) begin
      if ((ofs % (1 << rsh[s])) != 0 || ((ofs + len) % (1 << rsh[e])) != 0) expRej = 1;
    end
    if (expRej) return;
    chip = ofs >> CHIP_SHIFT; addr = ofs % CHIP_SIZE; r = s; o = ofs; rem = len;
    while (rem > 0 && expN < 64) begin
      sz = 1 << rsh[r];
      expChip[expN] = chip; expAddr[expN] = addr; expSize[expN] = sz;
      expN++;
      addr += sz; o += sz; rem = (rem > sz) ? rem - sz : 0;
      if (o == rs[r] + sz * rb[r] && r + 1 < n) r++;
      if (addr >= CHIP_SIZE) begin
        addr = 0; chip++;
        if (chip >= NUM_CHIPS) break;
      end
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one request; failAt = index of block answered with failCode (-1 none); lat = extra wait cycles
  task automatic runReq(int ofs, int len, int n, int failAt, int failCode, int lat, string tag);
    int idx = 0, waitCnt = 0, fails;
    int expIssued, expCode;
    model(ofs, len, n);
    @(negedge clk);
    reqOffset = OFS_W'(ofs); reqLength = OFS_W'(len); numRegions = 3'(n);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    forever begin
      if (done) break;
      if (blkValid && !blkDone) begin
        if (waitCnt < lat) begin
          waitCnt++;
        end else begin
          waitCnt = 0;
          total++;
          if (idx >= expN || expRej ||
              int'(blkChip) != expChip[idx] || int'(blkAddr) != expAddr[idx] ||
              int'(blkSize) != expSize[idx]) begin
            bad++;
            $display("FAIL %s R5 R6 R7 R8 R10 ofs=%0d len=%0d blk%0d: got chip=%0d addr=%0d size=%0d exp chip=%0d addr=%0d size=%0d (expN=%0d rej=%0d)",
                     tag, ofs, len, idx, blkChip, blkAddr, blkSize,
                     expChip[idx], expAddr[idx], expSize[idx], expN, expRej);
          end
          blkDone = 1'b1;
          blkStatus = (idx == failAt) ? ST_W'(failCode) : '0;
          idx++;
        end
      end else begin
        blkDone = 1'b0;
        blkStatus = '0;
      end
      @(negedge clk);
    end
    blkDone = 1'b0; blkStatus = '0;
    expIssued = (failAt >= 0 && failAt < expN) ? failAt + 1 : expN;
    expCode   = (failAt >= 0 && failAt < expN) ? failCode : 0;
    total++;
    fails = (idx != expIssued) || (int'(alignErr) != expRej) || (int'(errCode) != expCode);
    if (fails) begin
      bad++;
      $display("FAIL %s R2 R3 R4 R9 R11 ofs=%0d len=%0d n=%0d: got blocks=%0d alignErr=%0d errCode=%0d exp blocks=%0d alignErr=%0d errCode=%0d",
               tag, ofs, len, n, idx, alignErr, errCode, expIssued, expRej, expCode);
    end
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        bad++;
        $display("FAIL watchdog expired: got running exp finished");
        report();
      end
    end
  end

  initial begin
    int lens[6] = '{0, 16, 48, 64, 128, 256};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    total++;
    if (busy || blkValid || done || alignErr) begin
      bad++;
      $display("FAIL R1 reset: got busy=%0d valid=%0d done=%0d alignErr=%0d exp 0 0 0 0",
               busy, blkValid, done, alignErr);
    end
    // R2 R3 R4: explicit refusals
    runReq(8, 16, 4, -1, 0, 0, "R2 start misaligned");
    runReq(0, 8, 4, -1, 0, 0, "R3 end misaligned");
    runReq(128, 16, 4, -1, 0, 0, "R3 end in 64B region");
    // R10: zero length passes checks, no block
    runReq(384, 0, 4, -1, 0, 0, "R10 zero length");
    // R10: slow eraser, request held
    runReq(96, 96, 4, -1, 0, 3, "R10 held request");
    // R9: abort at second block
    runReq(0, 64, 4, 1, 5, 0, "R9 abort");
    runReq(1024, 512, 4, 0, 15, 1, "R9 abort first");
    // R8: chip carry and end of chips
    runReq(768, 512, 4, -1, 0, 0, "R8 chip carry");
    runReq(3840, 512, 4, -1, 0, 0, "R8 last chip stop");
    // R11: limited region count
    runReq(384, 128, 2, -1, 0, 0, "R11 two regions");
    runReq(0, 16, 0, -1, 0, 0, "R11 no regions");
    // R2 R3 R5 R6 R7: near-exhaustive sweep
    for (int o = 0; o < 4096; o += 16)
      for (int l = 0; l < 6; l++)
        runReq(o, lens[l], 4, -1, 0, 0, "sweep");
    for (int o = 0; o < 1024; o += 16)
      runReq(o, 64, 2, -1, 0, 0, "R11 sweep");
    report();
  end
endmodule